// File: doc/BRIEF.md
# Branch and Jump Next-Address Unit

This block holds the program counter of a 32-bit load/store processor and works out the address of the next instruction. Each cycle it looks at the current instruction word and the two source-register values. By default it steps to the following word. For a conditional branch it compares the two registers and, when the condition holds, moves to a target relative to the incremented address. For the unconditional jump it builds an absolute target inside the current 256 MB region.

The taken flag is combinational. It reports in the same cycle whether the instruction on the inputs redirects the flow. The new address appears on the PC output after the next rising clock edge. When the enable input is low, the PC holds its value and the flag stays low.

Top module: `npc_unit`

## Requirements
- R1: While reset is active, and on the first cycle after it is released, the PC output equals RESET_PC (default 0).
- R2: With enable high and an opcode (instr[31:26]) other than 2, 4 or 5, the PC advances by 4 at the next edge and taken stays low.
- R3: Opcode 4 (branch-if-equal) with rs_val equal to rt_val raises taken. The next PC is (PC+4) + (sign-extended instr[15:0] shifted left by 2). With unequal values, taken is low and the next PC is PC+4.
- R4: Opcode 5 (branch-if-not-equal) with rs_val different from rt_val raises taken and loads the same relative target as R3. With equal values, taken is low and the next PC is PC+4.
- R5: A negative 16-bit offset (bit 15 set) moves the PC backward from PC+4 by four times the offset's magnitude.
- R6: Opcode 2 (jump) raises taken. The next PC is {(PC+4)[31:28], instr[25:0], 2'b00}.
- R7: With enable low, the PC keeps its value and taken is low, whatever the instruction.
- R8: The 4 upper bits of a jump target come from PC+4, not from PC. A jump held at the last word of a region therefore lands in the next region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance enable; low stalls the PC |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | First source-register value |
| rt_val | input | 32 | Second source-register value |
| pc | output | 32 | Registered program counter |
| taken | output | 1 | Current instruction redirects the flow |

## Verification
A wrong decode or a wrong compare result shows on the taken flag in the same cycle as the instruction. A wrong target or increment shows on the PC one edge later, and every later address then stays offset, because each step builds on the previous PC. A jump issued from the last word of a region exposes upper bits taken from the wrong source in that single step. A stall that leaks shows as a PC change one edge after enable falls.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int ADDR_W   = 32;
    localparam int OP_W     = 6;
    localparam int OFF_W    = 16;
    localparam int TGT_W    = 26;
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = ADDR_W - TGT_W - ALIGN_W;
    localparam int STEP     = 1 << ALIGN_W;

    localparam logic [OP_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OP_W-1:0] OPC_BREQ = 6'd4;
    localparam logic [OP_W-1:0] OPC_BRNE = 6'd5;

    typedef enum logic [1:0] {
        FLOW_SEQ,
        FLOW_BREQ,
        FLOW_BRNE,
        FLOW_JUMP
    } flow_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } npc_state_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [ADDR_W-1:0] instr,
    output flow_e             flow
);
    logic [OP_W-1:0] opcode;

    always_comb begin
        opcode = instr[ADDR_W-1 -: OP_W];
        unique case (opcode)
            OPC_BREQ: flow = FLOW_BREQ;
            OPC_BRNE: flow = FLOW_BRNE;
            OPC_JUMP: flow = FLOW_JUMP;
            default:  flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_compare.sv
module npc_compare
    import npc_pkg::*;
(
    input  flow_e             flow,
    input  logic [ADDR_W-1:0] rs_val,
    input  logic [ADDR_W-1:0] rt_val,
    output logic              redirect
);
    logic same;

    always_comb begin
        same = (rs_val == rt_val);
        unique case (flow)
            FLOW_BREQ: redirect = same;
            FLOW_BRNE: redirect = !same;
            FLOW_JUMP: redirect = 1'b1;
            default:   redirect = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] instr,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] rel_addr,
    output logic [ADDR_W-1:0] abs_addr
);
    logic [OFF_W-1:0]  offset;
    logic [ADDR_W-1:0] disp;

    always_comb begin
        offset   = instr[OFF_W-1:0];
        seq_addr = pc + ADDR_W'(STEP);
        disp     = {{(ADDR_W-OFF_W-ALIGN_W){offset[OFF_W-1]}}, offset, {ALIGN_W{1'b0}}};
        rel_addr = seq_addr + disp;
        abs_addr = {seq_addr[ADDR_W-1 -: REGION_W], instr[TGT_W-1:0], {ALIGN_W{1'b0}}};
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc,
    output logic        taken
);
    npc_state_t        state_d, state_q;
    flow_e             flow;
    logic              redirect;
    logic [ADDR_W-1:0] seq_addr, rel_addr, abs_addr;

    npc_decode i_decode (
        .instr (instr),
        .flow  (flow)
    );

    npc_compare i_compare (
        .flow     (flow),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .redirect (redirect)
    );

    npc_targets i_targets (
        .pc       (state_q.pc),
        .instr    (instr),
        .seq_addr (seq_addr),
        .rel_addr (rel_addr),
        .abs_addr (abs_addr)
    );

    always_comb begin
        state_d = state_q;
        if (en) begin
            if (!redirect)
                state_d.pc = seq_addr;
            else if (flow == FLOW_JUMP)
                state_d.pc = abs_addr;
            else
                state_d.pc = rel_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q.pc <= RESET_PC;
        else
            state_q <= state_d;
    end

    assign pc    = state_q.pc;
    assign taken = en && redirect;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] pc,
    input logic        taken
);
    logic [31:0] pc_inc;
    logic [5:0]  op;
    assign pc_inc = pc + 32'd4;
    assign op     = instr[31:26];

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc == RESET_PC);

    a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !taken) |=> pc == $past(pc_inc));

    a_r3_equal_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 6'd4 && rs_val == rt_val) |-> taken);

    a_r4_notequal_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 6'd5 && rs_val != rt_val) |-> taken);

    a_r6_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 6'd2) |=> pc[31:28] == $past(pc_inc[31:28]));

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pc));

    a_r7_stall_no_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !taken);
endmodule

bind npc_unit npc_unit_chk #(.RESET_PC(RESET_PC)) i_npc_unit_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .pc     (pc),
    .taken  (taken)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc;
    logic        taken;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .en(en), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .taken(taken)
    );

    // instr, rs, rt, en, expected taken, expected PC after the edge
    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] rs;
        logic [31:0] rt;
        logic        en;
        logic        tk;
        logic [31:0] npc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h2000_0007, 32'd1, 32'd2, 1'b1, 1'b0, 32'h0000_0004}, // R2 other opcode
        '{32'h1000_0003, 32'd5, 32'd5, 1'b1, 1'b1, 32'h0000_0014}, // R3 equal taken
        '{32'h1000_0003, 32'd5, 32'd6, 1'b1, 1'b0, 32'h0000_0018}, // R3 unequal falls through
        '{32'h1400_0010, 32'd5, 32'd6, 1'b1, 1'b1, 32'h0000_005C}, // R4 differ taken
        '{32'h1400_0010, 32'd9, 32'd9, 1'b1, 1'b0, 32'h0000_0060}, // R4 equal falls through
        '{32'h0800_0100, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0000_0060}, // R7 stall with jump
        '{32'h1000_FFFC, 32'd3, 32'd3, 1'b1, 1'b1, 32'h0000_0054}, // R5 backward
        '{32'h0800_0100, 32'd0, 32'd1, 1'b1, 1'b1, 32'h0000_0400}, // R6 jump
        '{32'h0BFF_FFFF, 32'd0, 32'd0, 1'b1, 1'b1, 32'h0FFF_FFFC}, // R6 max target field
        '{32'h0800_0000, 32'd0, 32'd0, 1'b1, 1'b1, 32'h1000_0000}, // R8 region from PC+4
        '{32'h0800_0040, 32'd0, 32'd0, 1'b1, 1'b1, 32'h1000_0100}, // R8 stays in new region
        '{32'h1800_0005, 32'd4, 32'd4, 1'b1, 1'b0, 32'h1000_0104}  // R2 opcode 6 not a branch
    };

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check32("R1 pc in reset", pc, 32'h0);
        rst_n = 1'b1;
        #1 check32("R1 pc after release", pc, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr  = VECS[i].ins;
            rs_val = VECS[i].rs;
            rt_val = VECS[i].rt;
            en     = VECS[i].en;
            #1 check32($sformatf("vec %0d taken", i), {31'd0, taken}, {31'd0, VECS[i].tk});
            @(posedge clk); #1;
            check32($sformatf("vec %0d pc", i), pc, VECS[i].npc);
        end

        // R7: stall over several cycles with a satisfied branch
        @(negedge clk);
        en = 1'b0; instr = 32'h1000_0008; rs_val = 32'd1; rt_val = 32'd1;
        #1 check32("R7 taken low in stall", {31'd0, taken}, 32'd0);
        repeat (3) @(posedge clk);
        #1 check32("R7 pc held", pc, 32'h1000_0104);

        // R3: same branch released from stall
        @(negedge clk);
        en = 1'b1;
        #1 check32("R3 taken on release", {31'd0, taken}, 32'd1);
        @(posedge clk); #1;
        check32("R3 target on release", pc, 32'h1000_0128);

        // R5: most negative offset
        @(negedge clk);
        instr = 32'h1400_8000; rs_val = 32'd0; rt_val = 32'd7;
        @(posedge clk); #1;
        check32("R5 most negative offset", pc, 32'h0FFE_012C);

        // R1: reset in mid-run
        @(negedge clk);
        en = 1'b0;
        rst_n = 1'b0;
        #1 check32("R1 pc on mid-run reset", pc, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; en = 1'b1; instr = 32'h0000_0020;
        @(posedge clk); #1;
        check32("R2 step after reset", pc, 32'h4);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule